// File: doc/BRIEF.md
# One-Time-Programmable Word Store with Mode Decoder

This block is a synthesizable model of a 16-bit-wide programmable read-only word array. Five control inputs are decoded into operating modes: a chip enable, an output enable and a program strobe (all active low), plus two abstract flags that stand in for the high programming voltage and the high identifier voltage. The modes are read, output disable, program, verify, program inhibit, standby and identifier readout. Analog levels are not modelled. The read path is combinational from the controls and address to the data outputs and the drive qualifier. The array is updated only on the system clock.

A word leaves erase with every bit at 1. Programming can only clear bits: the new word is the old word ANDed with the write data. A write happens on the clock edge where the program strobe is first seen high after being seen low, provided the programming flag is on and chip enable is low at that edge. A synchronous erase input returns the array to all ones. Reset also leaves the array in the erased state.

Top module: `otp_word_store`

## Requirements
- R1: After reset, and on the clock edge after erase_i is sampled high, every word reads 0xFFFF.
- R2: On a clock edge where pgm_n_i is sampled high, and pgm_n_i was sampled low on the edge before, with hv_pgm_i high and ce_n_i low, the word at addr_i becomes its old value ANDed with wdata_i.
- R3: With ce_n_i=0, oe_n_i=0, pgm_n_i=1, hv_pgm_i=0 and hv_sig_i=0 (read), drive_o=1 and rdata_o shows the word at addr_i in the same cycle.
- R4: With ce_n_i=1 (standby, or program inhibit when hv_pgm_i=1), drive_o=0 whatever oe_n_i and the flags are.
- R5: With ce_n_i=0 and oe_n_i=1 (output disable), drive_o=0.
- R6: With hv_pgm_i=1, ce_n_i=0, oe_n_i=0, pgm_n_i=1 and hv_sig_i=0 (verify), drive_o=1 and rdata_o shows the word at addr_i.
- R7: With ce_n_i=0, oe_n_i=0 and hv_sig_i=1, drive_o=1 and rdata_o is 0x0020 when addr_i[0]=0 and 0x008C when addr_i[0]=1; the upper byte is zero. This takes priority over read and verify.
- R8: A strobe pulse with ce_n_i=1 leaves the addressed word unchanged, even when hv_pgm_i=1.
- R9: A strobe pulse with hv_pgm_i=0 leaves the addressed word unchanged.
- R10: Whenever drive_o=0, rdata_o is all zeros.
- R11: With ce_n_i=0, oe_n_i=0, pgm_n_i=0, hv_pgm_i=0 and hv_sig_i=0, drive_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; leaves the array erased |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| pgm_n_i | input | 1 | Program strobe, active low |
| hv_pgm_i | input | 1 | Programming-voltage flag |
| hv_sig_i | input | 1 | Identifier-voltage flag |
| erase_i | input | 1 | Synchronous erase to all ones |
| addr_i | input | AW | Word address |
| wdata_i | input | DW | Data presented for programming |
| rdata_o | output | DW | Read data, zero when not driving |
| drive_o | output | 1 | Output drive enable (low means high impedance) |

## Verification
The assertions assume that all control inputs are synchronous to clk_i and stable between edges, and that addr_i and wdata_i hold their values across the edge that commits a write. The bench changes every input only on the falling clock edge. Each program pulse holds the address, data, programming flag and chip enable from the falling edge that lowers the strobe until the falling edge after it is released. Mode combinations are applied one per cycle and are sampled in the second half of the low phase, after the combinational read path has settled.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_INHIBIT,
    MODE_OUT_OFF,
    MODE_READ,
    MODE_VERIFY,
    MODE_PROGRAM,
    MODE_IDENT,
    MODE_IDLE
  } otp_mode_e;

  localparam logic [15:0] IDENT_LO_CODE = 16'h0020;
  localparam logic [15:0] IDENT_HI_CODE = 16'h008C;
endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_pkg::*;
(
  input  logic      ce_n_i,
  input  logic      oe_n_i,
  input  logic      pgm_n_i,
  input  logic      hv_pgm_i,
  input  logic      hv_sig_i,
  output otp_mode_e mode_o,
  output logic      drive_o
);
  always_comb begin
    if (ce_n_i)                 mode_o = hv_pgm_i ? MODE_INHIBIT : MODE_STANDBY;
    else if (oe_n_i)            mode_o = (hv_pgm_i && !pgm_n_i) ? MODE_PROGRAM : MODE_OUT_OFF;
    else if (hv_sig_i)          mode_o = MODE_IDENT;     // identifier wins over read/verify
    else if (!pgm_n_i)          mode_o = hv_pgm_i ? MODE_PROGRAM : MODE_IDLE;
    else if (hv_pgm_i)          mode_o = MODE_VERIFY;
    else                        mode_o = MODE_READ;
  end

  always_comb begin
    unique case (mode_o)
      MODE_READ, MODE_VERIFY, MODE_IDENT: drive_o = 1'b1;
      default:                            drive_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/otp_strobe_edge.sv
module otp_strobe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_n_i,
  input  logic pgm_n_i,
  input  logic hv_pgm_i,
  output logic we_o
);
  logic pgm_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pgm_n_q <= 1'b1;
    else         pgm_n_q <= pgm_n_i;
  end

  // commit on strobe release, qualified at that edge
  assign we_o = !pgm_n_q && pgm_n_i && hv_pgm_i && !ce_n_i;
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          erase_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (erase_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we_i && (32'(addr_i) < DEPTH)) begin
      mem_q[addr_i] <= mem_q[addr_i] & wdata_i;   // bits only clear
    end
  end

  assign rdata_o = (32'(addr_i) < DEPTH) ? mem_q[addr_i] : '1;

  for (genvar k = 0; k < DEPTH; k++) begin : g_word_chk
    AST_ERASE_ALL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      erase_i |=> (mem_q[k] == '1)); // R1
    AST_BITS_ONLY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !erase_i |=> ((mem_q[k] & ~$past(mem_q[k])) == '0)); // R2
    AST_WRITE_MERGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && !erase_i && (32'(addr_i) == k))
        |=> (mem_q[k] == ($past(mem_q[k]) & $past(wdata_i)))); // R2
  end
endmodule

// File: rtl/otp_word_store.sv
module otp_word_store
  import otp_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_n_i,
  input  logic          oe_n_i,
  input  logic          pgm_n_i,
  input  logic          hv_pgm_i,
  input  logic          hv_sig_i,
  input  logic          erase_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          drive_o
);
  otp_mode_e     mode;
  logic          dec_drive;
  logic          we;
  logic [DW-1:0] cell_data;
  logic [DW-1:0] ident_data;

  otp_mode_dec i_dec (
    .ce_n_i   (ce_n_i),
    .oe_n_i   (oe_n_i),
    .pgm_n_i  (pgm_n_i),
    .hv_pgm_i (hv_pgm_i),
    .hv_sig_i (hv_sig_i),
    .mode_o   (mode),
    .drive_o  (dec_drive)
  );

  otp_strobe_edge i_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_n_i   (ce_n_i),
    .pgm_n_i  (pgm_n_i),
    .hv_pgm_i (hv_pgm_i),
    .we_o     (we)
  );

  otp_cell_array #(.DW(DW), .DEPTH(DEPTH)) i_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .erase_i (erase_i),
    .we_i    (we),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (cell_data)
  );

  assign ident_data = addr_i[0] ? DW'(IDENT_HI_CODE) : DW'(IDENT_LO_CODE);

  always_comb begin
    rdata_o = '0;
    if (dec_drive) rdata_o = (mode == MODE_IDENT) ? ident_data : cell_data;
  end
  assign drive_o = dec_drive;

  AST_DESELECT_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_n_i |-> !drive_o); // R4
  AST_OUTPUT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_i && oe_n_i) |-> !drive_o); // R5
  AST_IDENT_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_i && !oe_n_i && hv_sig_i) |-> (drive_o && rdata_o[DW-1:8] == '0)); // R7
  AST_UNDRIVEN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_o |-> (rdata_o == '0)); // R10
  AST_WRITE_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> (hv_pgm_i && !ce_n_i && pgm_n_i)); // R8
  AST_NO_HV_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hv_pgm_i |-> !we); // R9
endmodule

// File: tb/test_otp_word_store.sv
module test_otp_word_store;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int AW = 4;
  // {req[3:0], ce_n, oe_n, pgm_n, hv_pgm, hv_sig, addr[3:0], exp_drive, exp_data[15:0]}
  localparam int VW = 30;
  localparam int NV = 14;
  localparam logic [VW-1:0] VECS [NV] = '{
    {4'd3,  1'b0,1'b0,1'b1,1'b0,1'b0, 4'd3, 1'b1, 16'h05F0},  // R3 twice-programmed word
    {4'd3,  1'b0,1'b0,1'b1,1'b0,1'b0, 4'd9, 1'b1, 16'h1234},  // R3
    {4'd8,  1'b0,1'b0,1'b1,1'b0,1'b0, 4'd5, 1'b1, 16'hFFFF},  // R8 inhibited word intact
    {4'd9,  1'b0,1'b0,1'b1,1'b0,1'b0, 4'd6, 1'b1, 16'hFFFF},  // R9 no-flag word intact
    {4'd5,  1'b0,1'b1,1'b1,1'b0,1'b0, 4'd3, 1'b0, 16'h0000},  // R5
    {4'd4,  1'b1,1'b0,1'b1,1'b0,1'b0, 4'd3, 1'b0, 16'h0000},  // R4 standby
    {4'd4,  1'b1,1'b0,1'b1,1'b1,1'b0, 4'd9, 1'b0, 16'h0000},  // R4 inhibit
    {4'd6,  1'b0,1'b0,1'b1,1'b1,1'b0, 4'd9, 1'b1, 16'h1234},  // R6
    {4'd7,  1'b0,1'b0,1'b1,1'b0,1'b1, 4'd0, 1'b1, 16'h0020},  // R7
    {4'd7,  1'b0,1'b0,1'b1,1'b0,1'b1, 4'd1, 1'b1, 16'h008C},  // R7
    {4'd7,  1'b0,1'b0,1'b1,1'b0,1'b1, 4'd3, 1'b1, 16'h008C},  // R7 over stored data
    {4'd7,  1'b0,1'b0,1'b1,1'b1,1'b1, 4'd8, 1'b1, 16'h0020},  // R7 over verify
    {4'd11, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd3, 1'b0, 16'h0000},  // R11
    {4'd10, 1'b1,1'b0,1'b1,1'b0,1'b1, 4'd1, 1'b0, 16'h0000}   // R10 deselected identifier
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ce_n_i = 1'b1, oe_n_i = 1'b1, pgm_n_i = 1'b1;
  logic          hv_pgm_i = 1'b0, hv_sig_i = 1'b0, erase_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          drive_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10ns clk_i = ~clk_i;

  otp_word_store #(.DW(DW), .DEPTH(DEPTH)) i_otp_word_store (
    .clk_i, .rst_ni, .ce_n_i, .oe_n_i, .pgm_n_i, .hv_pgm_i, .hv_sig_i,
    .erase_i, .addr_i, .wdata_i, .rdata_o, .drive_o
  );

  task automatic check(input int req, input logic exp_drv, input logic [DW-1:0] exp_dat);
    checks++;
    if (drive_o !== exp_drv || rdata_o !== exp_dat) begin
      fails++;
      $display("FAIL R%0d: drive=%b data=%h, expected drive=%b data=%h",
               req, drive_o, rdata_o, exp_drv, exp_dat);
    end
  endtask

  task automatic read_word(input logic [AW-1:0] a);
    @(negedge clk_i);
    ce_n_i = 0; oe_n_i = 0; pgm_n_i = 1; hv_pgm_i = 0; hv_sig_i = 0; addr_i = a;
    #5ns;
  endtask

  task automatic pulse(input logic ce_n, input logic hv, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
    @(negedge clk_i);
    ce_n_i = ce_n; oe_n_i = 1; hv_pgm_i = hv; hv_sig_i = 0; addr_i = a; wdata_i = d;
    pgm_n_i = 0;
    @(negedge clk_i);
    pgm_n_i = 1;
    @(negedge clk_i);
    hv_pgm_i = 0; ce_n_i = 1;
  endtask

  initial begin
    #5ms;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 erased after reset
    read_word(4'd3);  check(1, 1'b1, 16'hFFFF);
    read_word(4'd15); check(1, 1'b1, 16'hFFFF);
    // R2 writes, AND merge
    pulse(1'b0, 1'b1, 4'd3, 16'hA5F0);
    read_word(4'd3);  check(2, 1'b1, 16'hA5F0);
    pulse(1'b0, 1'b1, 4'd3, 16'h0FFF);
    read_word(4'd3);  check(2, 1'b1, 16'h05F0);
    pulse(1'b0, 1'b1, 4'd3, 16'hFFFF);   // R2 ones cannot set bits
    read_word(4'd3);  check(2, 1'b1, 16'h05F0);
    pulse(1'b0, 1'b1, 4'd9, 16'h1234);
    // R8 deselected pulse, R9 pulse without flag
    pulse(1'b1, 1'b1, 4'd5, 16'h0000);
    pulse(1'b0, 1'b0, 4'd6, 16'h0000);
    // R2 strobe held low writes nothing until release
    @(negedge clk_i);
    ce_n_i = 0; oe_n_i = 1; hv_pgm_i = 1; addr_i = 4'd12; wdata_i = 16'h00FF; pgm_n_i = 0;
    repeat (3) @(negedge clk_i);
    oe_n_i = 0; hv_pgm_i = 0; pgm_n_i = 1;  // release without flag: no write
    #5ns;
    check(2, 1'b1, 16'hFFFF);
    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      {ce_n_i, oe_n_i, pgm_n_i, hv_pgm_i, hv_sig_i, addr_i} = VECS[i][25:17];
      #5ns;
      check(int'(VECS[i][29:26]), VECS[i][16], VECS[i][15:0]);
    end
    // R1 erase
    @(negedge clk_i);
    ce_n_i = 1; erase_i = 1;
    @(negedge clk_i);
    erase_i = 0;
    read_word(4'd3); check(1, 1'b1, 16'hFFFF);
    read_word(4'd9); check(1, 1'b1, 16'hFFFF);
    // R2 after erase the word programs again
    pulse(1'b0, 1'b1, 4'd9, 16'h5A5A);
    read_word(4'd9); check(2, 1'b1, 16'h5A5A);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule